// File: doc/BRIEF.md
# Strobed FIFO with Read Rewind

A first-in, first-out buffer for a synchronous design that is driven by active-low read and write strobes instead of per-cycle enables. Each strobe is synchronized into the block clock, and its edges are detected there. A falling write edge stores the word on the input bus. A falling read edge presents the oldest stored word on the output bus, together with a valid indication. That indication stays high until the read strobe rises and so stands in for a tri-stated bus. Active-low flags report empty, full and more-than-half-full.

A retransmit input, pulsed low while both strobes are idle, moves the read pointer back to the first location. The write pointer is left where it is, so data written since reset can be read again. Pointers carry one extra bit, which lets a completely full buffer be told apart from an empty one. Storage is a simple dual-port array, so it maps onto block RAM. The width and the address bits are parameters, and the depth is two to the power of the address bits (1024 words by default).

Top module: `strobe_fifo`

## Requirements
- R1: After a synchronous reset, empty_n is 0, full_n is 1, half_n is 1, dout_vld is 0 and proto_err is 0.
- R2: A falling edge on wr_n stores din when full_n is 1. A falling edge on rd_n when empty_n is 1 raises dout_vld with the oldest unread word on dout, so words leave in the order they were written. Each edge takes effect in the third clock cycle after it reaches the pin.
- R3: When rd_n rises after an accepted read, dout_vld returns to 0 and stays there until the next accepted read.
- R4: empty_n is 0 exactly when the read and write pointers are equal. A read strobe while empty leaves dout_vld at 0 and does not move the read pointer.
- R5: full_n goes to 0 once DEPTH words are held, which from reset takes exactly DEPTH writes with no reads. Write strobes while full store nothing, and the first completed read returns full_n to 1.
- R6: half_n goes to 0 on the write edge that raises the fill level above DEPTH/2. It stays 0 across the falling edge of a later read and returns to 1 only on a rising read edge with the fill level at or below DEPTH/2.
- R7: A low pulse on rt_n returns the read pointer to location 0 and leaves the write pointer as it is. Later reads replay the words from the first one written since reset.
- R8: During a retransmit, empty_n, full_n and half_n are recomputed from the write pointer's new distance to the rewound read pointer.
- R9: Strobe edges that arrive during a retransmit are ignored. proto_err pulses high for any such edge, or for a strobe held low while retransmit is active.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_n | input | 1 | Write strobe, active low, asynchronous |
| rd_n | input | 1 | Read strobe, active low, asynchronous |
| rt_n | input | 1 | Retransmit request, active low |
| din | input | DATA_W | Write data, stable while wr_n is low |
| dout | output | DATA_W | Read data, meaningful while dout_vld is 1 |
| dout_vld | output | 1 | Read data valid (stands in for a driven bus) |
| full_n | output | 1 | Full flag, active low |
| empty_n | output | 1 | Empty flag, active low |
| half_n | output | 1 | More-than-half-full flag, active low |
| proto_err | output | 1 | One-cycle pulse on strobe activity during retransmit |

## Verification
The hardest state to reach from the pins is a retransmit while the half-full flag disagrees with the rewound distance. The bench writes past the half mark and then reads back until the flag clears on a rising read edge. Only then does it pulse rt_n, and it checks that half_n drops again while no write has happened. A second hard case is a completely full buffer receiving one more write. The bench fills it to exactly DEPTH words, issues a write with a marker value, and then drains the buffer. The scoreboard confirms that the marker never appears and that the replay and drain orders match.

// File: rtl/strobe_fifo_pkg.sv
package strobe_fifo_pkg;
  // Synchronized view of one asynchronous active-low strobe.
  typedef struct packed {
    logic fall;   // one-cycle pulse: pin went low
    logic rise;   // one-cycle pulse: pin went high
    logic level;  // synchronized pin level
  } strobe_evt_t;

  localparam int unsigned N_STROBES = 3;
  localparam int unsigned IDX_WR    = 0;
  localparam int unsigned IDX_RD    = 1;
  localparam int unsigned IDX_RT    = 2;
endpackage

// File: rtl/strobe_edge.sv
module strobe_edge
  import strobe_fifo_pkg::*;
#(
  parameter int unsigned STAGES = 2
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        pin_n,
  output strobe_evt_t evt
);
  // sh[STAGES-1] is the synchronized level, sh[STAGES] its previous value.
  logic [STAGES:0] sh;

  always_ff @(posedge clk) begin
    if (rst) sh <= '1;
    else     sh <= {sh[STAGES-1:0], pin_n};
  end

  always_comb begin
    evt.level = sh[STAGES-1];
    evt.fall  = sh[STAGES] & ~sh[STAGES-1];
    evt.rise  = ~sh[STAGES] & sh[STAGES-1];
  end
endmodule

// File: rtl/fifo_ram.sv
module fifo_ram #(
  parameter int unsigned DATA_W = 9,
  parameter int unsigned ADDR_W = 10
) (
  input  logic              clk,
  input  logic              we,
  input  logic [ADDR_W-1:0] waddr,
  input  logic [DATA_W-1:0] wdata,
  input  logic              re,
  input  logic [ADDR_W-1:0] raddr,
  output logic [DATA_W-1:0] rdata
);
  localparam int unsigned DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  always_ff @(posedge clk) begin
    if (re) rdata <= mem[raddr];
  end
endmodule

// File: rtl/fifo_ptr_ctrl.sv
module fifo_ptr_ctrl
  import strobe_fifo_pkg::*;
#(
  parameter int unsigned ADDR_W = 10
) (
  input  logic              clk,
  input  logic              rst,
  input  strobe_evt_t       wr_evt,
  input  strobe_evt_t       rd_evt,
  input  strobe_evt_t       rt_evt,
  output logic [ADDR_W:0]   wr_ptr,
  output logic [ADDR_W:0]   rd_ptr,
  output logic              wr_en,
  output logic              rd_en,
  output logic              rt_act,
  output logic              rd_busy,
  output logic              full_n,
  output logic              empty_n,
  output logic              half_n,
  output logic              proto_err
);
  localparam int unsigned PTR_W = ADDR_W + 1;
  localparam int unsigned DEPTH = 1 << ADDR_W;
  localparam logic [PTR_W-1:0] FULL_LVL = PTR_W'(DEPTH);
  localparam logic [PTR_W-1:0] HALF_LVL = PTR_W'(DEPTH / 2);

  logic             full_q, empty_q, half_q, perr_q;
  logic [PTR_W-1:0] wp_nxt, rp_nxt, cnt_nxt;
  logic             strobe_activity;

  // Retransmit window: synchronized low level, stretched through the release cycle.
  assign rt_act = rt_evt.fall | ~rt_evt.level | rt_evt.rise;

  assign wr_en = wr_evt.fall & ~full_q  & ~rt_act;
  assign rd_en = rd_evt.fall & ~empty_q & ~rt_act;

  assign strobe_activity = wr_evt.fall | wr_evt.rise | rd_evt.fall | rd_evt.rise
                         | ~wr_evt.level | ~rd_evt.level;

  always_comb begin
    wp_nxt  = wr_ptr + PTR_W'(wr_en);
    rp_nxt  = rt_act ? '0 : rd_ptr + PTR_W'(rd_en);
    cnt_nxt = wp_nxt - rp_nxt;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_ptr  <= '0;
      rd_ptr  <= '0;
      full_q  <= 1'b0;
      empty_q <= 1'b1;
      half_q  <= 1'b0;
      rd_busy <= 1'b0;
      perr_q  <= 1'b0;
    end else begin
      wr_ptr  <= wp_nxt;
      rd_ptr  <= rp_nxt;
      full_q  <= (cnt_nxt == FULL_LVL);
      empty_q <= (cnt_nxt == '0);
      perr_q  <= rt_act & strobe_activity;

      if (rd_en)            rd_busy <= 1'b1;
      else if (rd_evt.rise) rd_busy <= 1'b0;

      // Asymmetric half flag: set by a write edge, cleared by a read release.
      if (rt_act)
        half_q <= (cnt_nxt > HALF_LVL);
      else if (wr_en && (cnt_nxt > HALF_LVL))
        half_q <= 1'b1;
      else if (rd_evt.rise && (cnt_nxt <= HALF_LVL))
        half_q <= 1'b0;
    end
  end

  assign full_n    = ~full_q;
  assign empty_n   = ~empty_q;
  assign half_n    = ~half_q;
  assign proto_err = perr_q;
endmodule

// File: rtl/strobe_fifo.sv
module strobe_fifo
  import strobe_fifo_pkg::*;
#(
  parameter int unsigned DATA_W    = 9,
  parameter int unsigned ADDR_W    = 10,
  parameter int unsigned SYNC_STGS = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_n,
  input  logic              rd_n,
  input  logic              rt_n,
  input  logic [DATA_W-1:0] din,
  output logic [DATA_W-1:0] dout,
  output logic              dout_vld,
  output logic              full_n,
  output logic              empty_n,
  output logic              half_n,
  output logic              proto_err
);
  logic [N_STROBES-1:0] pins_n;
  strobe_evt_t          evt [N_STROBES];
  logic [ADDR_W:0]      wr_ptr, rd_ptr;
  logic                 wr_en, rd_en, rt_act;

  assign pins_n[IDX_WR] = wr_n;
  assign pins_n[IDX_RD] = rd_n;
  assign pins_n[IDX_RT] = rt_n;

  for (genvar g = 0; g < N_STROBES; g++) begin : g_sync
    strobe_edge #(.STAGES(SYNC_STGS)) u_edge (
      .clk   (clk),
      .rst   (rst),
      .pin_n (pins_n[g]),
      .evt   (evt[g])
    );
  end

  fifo_ptr_ctrl #(.ADDR_W(ADDR_W)) u_ctrl (
    .clk       (clk),
    .rst       (rst),
    .wr_evt    (evt[IDX_WR]),
    .rd_evt    (evt[IDX_RD]),
    .rt_evt    (evt[IDX_RT]),
    .wr_ptr    (wr_ptr),
    .rd_ptr    (rd_ptr),
    .wr_en     (wr_en),
    .rd_en     (rd_en),
    .rt_act    (rt_act),
    .rd_busy   (dout_vld),
    .full_n    (full_n),
    .empty_n   (empty_n),
    .half_n    (half_n),
    .proto_err (proto_err)
  );

  fifo_ram #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_ram (
    .clk   (clk),
    .we    (wr_en),
    .waddr (wr_ptr[ADDR_W-1:0]),
    .wdata (din),
    .re    (rd_en),
    .raddr (rd_ptr[ADDR_W-1:0]),
    .rdata (dout)
  );
endmodule

// File: rtl/strobe_fifo_chk.sv
module strobe_fifo_chk #(
  parameter int unsigned ADDR_W = 10
) (
  input logic            clk,
  input logic            rst,
  input logic            full_n,
  input logic            empty_n,
  input logic            dout_vld,
  input logic            rt_act,
  input logic [ADDR_W:0] wr_ptr,
  input logic [ADDR_W:0] rd_ptr
);
  localparam logic [ADDR_W:0] CAP = (ADDR_W + 1)'(1 << ADDR_W);

  assert_full_freezes_wp_R5: assert property (@(posedge clk) disable iff (rst)
    !full_n |=> $stable(wr_ptr));

  assert_empty_freezes_rp_R4: assert property (@(posedge clk) disable iff (rst)
    (!empty_n && !rt_act) |=> $stable(rd_ptr));

  assert_fill_bounded_R5: assert property (@(posedge clk) disable iff (rst)
    (wr_ptr - rd_ptr) <= CAP);

  assert_not_full_and_empty_R4: assert property (@(posedge clk) disable iff (rst)
    !(!full_n && !empty_n));

  assert_valid_needs_data_R2: assert property (@(posedge clk) disable iff (rst)
    $rose(dout_vld) |-> $past(empty_n));

  assert_rewind_zero_R7: assert property (@(posedge clk) disable iff (rst)
    rt_act |=> (rd_ptr == '0));
endmodule

bind strobe_fifo strobe_fifo_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk      (clk),
  .rst      (rst),
  .full_n   (full_n),
  .empty_n  (empty_n),
  .dout_vld (dout_vld),
  .rt_act   (rt_act),
  .wr_ptr   (wr_ptr),
  .rd_ptr   (rd_ptr)
);

// File: tb/test_strobe_fifo.sv
`timescale 1ns/1ps
module test_strobe_fifo;
  localparam int DATA_W = 9;
  localparam int ADDR_W = 4;
  localparam int DEPTH  = 1 << ADDR_W;
  localparam int HOLD   = 5;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic wr_n = 1'b1, rd_n = 1'b1, rt_n = 1'b1;
  logic [DATA_W-1:0] din = '0;
  logic [DATA_W-1:0] dout;
  logic dout_vld, full_n, empty_n, half_n, proto_err;

  int n_run = 0;
  int n_fail = 0;
  int model_cnt = 0;
  logic [DATA_W-1:0] exp_q[$];
  logic [DATA_W-1:0] hist[$];
  logic vld_d = 1'b0;
  logic err_seen = 1'b0;
  bit   done = 1'b0;

  always #2.5 clk = ~clk;

  strobe_fifo #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) i_strobe_fifo (
    .clk(clk), .rst(rst), .wr_n(wr_n), .rd_n(rd_n), .rt_n(rt_n), .din(din),
    .dout(dout), .dout_vld(dout_vld), .full_n(full_n), .empty_n(empty_n),
    .half_n(half_n), .proto_err(proto_err)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // Monitor: each new valid read word is popped from the scoreboard (R2 order).
  always @(negedge clk) begin
    if (!rst && dout_vld && !vld_d) begin
      if (exp_q.size() == 0) chk(1'b0, "R2 unexpected read data", int'(dout), -1);
      else begin
        logic [DATA_W-1:0] e;
        e = exp_q.pop_front();
        chk(dout == e, "R2 fifo order", int'(dout), int'(e));
      end
    end
    vld_d = dout_vld;
    if (!rst && proto_err) err_seen = 1'b1;
  end

  task automatic wait_n(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic do_reset();
    rst = 1'b1; wait_n(3); rst = 1'b0; wait_n(2);
    exp_q.delete(); hist.delete(); model_cnt = 0; err_seen = 1'b0;
  endtask

  task automatic wr_word(input logic [DATA_W-1:0] d);
    din = d;
    if (model_cnt < DEPTH) begin
      exp_q.push_back(d); hist.push_back(d); model_cnt++;
    end
    @(negedge clk); wr_n = 1'b0; wait_n(HOLD);
    wr_n = 1'b1; wait_n(HOLD);
  endtask

  task automatic rd_word();
    bit was_empty;
    was_empty = (model_cnt == 0);
    rd_n = 1'b0; wait_n(HOLD);
    if (was_empty) chk(dout_vld == 1'b0, "R4 read while empty", dout_vld, 0);
    rd_n = 1'b1; wait_n(HOLD);
    chk(dout_vld == 1'b0, "R3 valid drops after release", dout_vld, 0);
    if (!was_empty) model_cnt--;
  endtask

  task automatic retransmit();
    rt_n = 1'b0; wait_n(HOLD);
    rt_n = 1'b1; wait_n(HOLD);
    exp_q = hist;
    model_cnt = hist.size();
  endtask

  initial begin
    #(5ns * 150000);
    if (!done) begin
      n_fail++; n_run++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    do_reset();
    // R1 reset state
    chk(empty_n == 1'b0, "R1 empty_n", empty_n, 0);
    chk(full_n == 1'b1, "R1 full_n", full_n, 1);
    chk(half_n == 1'b1, "R1 half_n", half_n, 1);
    chk(dout_vld == 1'b0, "R1 dout_vld", dout_vld, 0);
    chk(proto_err == 1'b0, "R1 proto_err", proto_err, 0);

    // R2 basic order, R4 empty after drain and read ignored while empty
    wr_word(9'h1A5); wr_word(9'h05A); wr_word(9'h100);
    chk(empty_n == 1'b1, "R4 not empty after write", empty_n, 1);
    for (int i = 0; i < 3; i++) rd_word();
    chk(empty_n == 1'b0, "R4 empty after drain", empty_n, 0);
    rd_word();
    chk(exp_q.size() == 0, "R2 all words returned", exp_q.size(), 0);
    chk(err_seen == 1'b0, "R9 no error in normal use", err_seen, 0);

    // R6 asymmetric half flag
    do_reset();
    for (int i = 0; i < DEPTH / 2; i++) wr_word(DATA_W'(9'h020 + i));
    chk(half_n == 1'b1, "R6 at half not flagged", half_n, 1);
    wr_word(9'h0FF);
    chk(half_n == 1'b0, "R6 set above half", half_n, 0);
    rd_n = 1'b0; wait_n(HOLD);
    chk(half_n == 1'b0, "R6 held through read fall", half_n, 0);
    rd_n = 1'b1; wait_n(HOLD);
    model_cnt--;
    chk(half_n == 1'b1, "R6 cleared on read rise", half_n, 1);

    // R5 full, extra write ignored, full clears after read
    do_reset();
    for (int i = 0; i < DEPTH; i++) wr_word(DATA_W'(i * 7 + 1));
    chk(full_n == 1'b0, "R5 full after DEPTH writes", full_n, 0);
    wr_word(9'h1AA);
    chk(full_n == 1'b0, "R5 still full", full_n, 0);
    rd_word();
    chk(full_n == 1'b1, "R5 full clears after read", full_n, 1);
    for (int i = 1; i < DEPTH; i++) rd_word();
    chk(empty_n == 1'b0, "R5 drained exactly DEPTH words", empty_n, 0);
    chk(exp_q.size() == 0, "R5 no extra word stored", exp_q.size(), 0);

    // R7 / R8 retransmit replay and flag recompute
    do_reset();
    for (int i = 0; i < 10; i++) wr_word(DATA_W'(9'h100 + i));
    for (int i = 0; i < 4; i++) rd_word();
    chk(half_n == 1'b1, "R6 cleared at six words", half_n, 1);
    retransmit();
    chk(half_n == 1'b0, "R8 half recomputed", half_n, 0);
    chk(empty_n == 1'b1, "R8 empty recomputed", empty_n, 1);
    for (int i = 0; i < 10; i++) rd_word();
    chk(empty_n == 1'b0, "R7 write pointer kept", empty_n, 0);
    chk(exp_q.size() == 0, "R7 full replay", exp_q.size(), 0);

    // R9 write during retransmit ignored and reported
    do_reset();
    wr_word(9'h011); wr_word(9'h022);
    rt_n = 1'b0; wait_n(HOLD);
    din = 9'h155; wr_n = 1'b0; wait_n(HOLD);
    wr_n = 1'b1; wait_n(HOLD);
    rt_n = 1'b1; wait_n(HOLD);
    exp_q = hist; model_cnt = hist.size();
    chk(err_seen == 1'b1, "R9 proto_err pulsed", err_seen, 1);
    rd_word(); rd_word();
    chk(empty_n == 1'b0, "R9 write ignored", empty_n, 0);
    chk(exp_q.size() == 0, "R9 replay complete", exp_q.size(), 0);

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule